// File: doc/BRIEF.md
# Real-Time Clock Counter with Alarm Compare

This block is a real-time-clock peripheral that sits on a simple single-cycle register bus. A slow crystal clock of nominally 32.768 kHz enters on `rtc_src`. It is oversampled in the fast bus clock domain, and each rising edge becomes a one-cycle source pulse. A half-period divider turns those pulses into count ticks, one tick every 2×(DIV+1) source edges. With DIV = 1023 this gives 16 ticks per second, so the low four counter bits are fractions of a second.

A 32-bit counter advances by one on each tick, wraps to zero after all ones, and can be loaded from the bus. An alarm-compare register raises a sticky event flag when the counter steps onto its value while the alarm is enabled. Every tick also raises a sticky tick event. The interrupt is the registered OR of each event flag gated by its enable bit. The status register therefore mixes write-1-to-clear event flags with plain read/write enable bits. A second alarm value, a scratch word and a clock-select field are plain storage.

The counter counts only while the clock-select field holds 3, which selects the crystal. All state lives in the bus clock domain, so every counter read returns a settled value.

Top module: `rtc_core`

## Requirements
- R1: After reset, every mapped register (counter 0x00, alarm0 0x04, status 0x08, divider 0x0C, alarm1 0x18, clock select 0x1C, scratch 0x40) reads 0 and `irq` is 0.
- R2: Scratch (32 bits), alarm0 (32 bits), alarm1 (32 bits), divider (low 16 bits) and clock select (low 2 bits) read back what was last written, zero-extended. The scratch and alarm1 values have no effect on counting.
- R3: A read of any offset outside the map returns 0, and a write to it changes no mapped register. Offset 0x14 counts as outside the map.
- R4: The counter advances only while clock select equals 3. It advances by one every 2×(DIV+1) rising edges of `rtc_src`, and writing the divider restarts the divider phase.
- R5: A write to offset 0x00 loads the counter directly and wins over a tick in the same cycle. Back-to-back reads between ticks return the same value.
- R6: The counter wraps from 0xFFFFFFFF to 0 on the next tick.
- R7: Status bit 0 is the alarm0 event, bit 1 the tick event, bit 2 the alarm0 enable, bit 3 the tick enable and bit 6 the alarm1 enable. Bit 4 (alarm1 event) and all other bits read 0. The event bits clear when 1 is written to them and are left unchanged when 0 is written. The enable bits take the written value.
- R8: The tick event sets on every tick, whatever the tick enable holds.
- R9: The alarm0 event sets in the cycle in which a tick moves the counter onto the alarm0 value while the alarm0 enable is 1. It never sets while the enable is 0, and a set in the same cycle wins over a clear.
- R10: `irq` is 1 one cycle after (alarm0 event AND alarm0 enable) OR (tick event AND tick enable) holds, and 0 one cycle after neither holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock, all state is clocked here |
| rst | input | 1 | Synchronous active-high reset |
| rtc_src | input | 1 | Slow crystal clock, sampled as data |
| bus_en | input | 1 | Bus access strobe for one cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read, held otherwise |
| irq | output | 1 | Registered interrupt |

## Verification
Counting is checked with two divider settings, 1 and 3, which together separate the 2×(DIV+1) rate from nearby formulas. Counting is also checked with clock select at values other than 3, to show that ticks are gated off. All later reads are placed on a tick grid taken from the first interrupt edge, so the counter value is known in every window. Inside that grid the status tests move through enables on and off, written zeros against written ones, and an alarm value reached with the enable off and then with it on. This separates sticky events from level compares and separates gating from setting. A counter load placed exactly on the tick edge separates load priority from tick priority, and a load of all ones exercises the wrap.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  localparam int unsigned OFF_COUNT  = 'h00;
  localparam int unsigned OFF_ALARM0 = 'h04;
  localparam int unsigned OFF_STATUS = 'h08;
  localparam int unsigned OFF_DIV    = 'h0C;
  localparam int unsigned OFF_ALARM1 = 'h18;
  localparam int unsigned OFF_CLKSEL = 'h1C;
  localparam int unsigned OFF_SCRAT  = 'h40;

  localparam int ST_AL0_EV  = 0;
  localparam int ST_TICK_EV = 1;
  localparam int ST_AL0_EN  = 2;
  localparam int ST_TICK_EN = 3;
  localparam int ST_AL1_EN  = 6;

  localparam int unsigned CLK_SEL_XTAL = 3;

  function automatic logic reg_mapped(input int unsigned off);
    case (off)
      OFF_COUNT, OFF_ALARM0, OFF_STATUS, OFF_DIV,
      OFF_ALARM1, OFF_CLKSEL, OFF_SCRAT: return 1'b1;
      default:                           return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/rtc_src_sync.sv
module rtc_src_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic src,
  output logic src_rise
);
  localparam int N = (STAGES < 2) ? 2 : STAGES;

  logic [N-1:0] sh_q;
  logic         last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q   <= '0;
      last_q <= 1'b0;
    end else begin
      sh_q   <= {sh_q[N-2:0], src};
      last_q <= sh_q[N-1];
    end
  end

  assign src_rise = sh_q[N-1] & ~last_q;
endmodule

// File: rtl/rtc_tick_div.sv
module rtc_tick_div #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             src_pulse,
  input  logic [DIV_W-1:0] div_val,
  output logic             tick
);
  logic [DIV_W-1:0] half_cnt_q;
  logic             phase_q;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      half_cnt_q <= '0;
      phase_q    <= 1'b0;
      tick       <= 1'b0;
    end else begin
      tick <= 1'b0;
      if (src_pulse) begin
        if (half_cnt_q == div_val) begin
          half_cnt_q <= '0;
          phase_q    <= ~phase_q;
          tick       <= phase_q;
        end else begin
          half_cnt_q <= half_cnt_q + DIV_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/rtc_counter.sv
module rtc_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] alarm_val,
  input  logic             alarm_en,
  output logic [CNT_W-1:0] cnt,
  output logic             alarm_hit
);
  logic [CNT_W-1:0] cnt_inc;

  assign cnt_inc   = cnt + CNT_W'(1);
  assign alarm_hit = tick & ~load & alarm_en & (cnt_inc == alarm_val);

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (load) cnt <= load_val;
    else if (tick) cnt <= cnt_inc;
  end
endmodule

// File: rtl/rtc_core.sv
module rtc_core
  import rtc_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 32,
  parameter int DIV_W       = 16,
  parameter int SEL_W       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rtc_src,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  localparam logic [SEL_W-1:0] SEL_XTAL = SEL_W'(CLK_SEL_XTAL);

  logic wr, rd;
  logic h_cnt, h_al0, h_st, h_div, h_al1, h_sel, h_scr;

  assign wr    = bus_en & bus_we;
  assign rd    = bus_en & ~bus_we;
  assign h_cnt = (bus_addr == ADDR_W'(OFF_COUNT));
  assign h_al0 = (bus_addr == ADDR_W'(OFF_ALARM0));
  assign h_st  = (bus_addr == ADDR_W'(OFF_STATUS));
  assign h_div = (bus_addr == ADDR_W'(OFF_DIV));
  assign h_al1 = (bus_addr == ADDR_W'(OFF_ALARM1));
  assign h_sel = (bus_addr == ADDR_W'(OFF_CLKSEL));
  assign h_scr = (bus_addr == ADDR_W'(OFF_SCRAT));

  logic [DATA_W-1:0] alarm0_q, alarm1_q, scratch_q;
  logic [DIV_W-1:0]  div_q;
  logic [SEL_W-1:0]  sel_q;
  logic ev_al0_q, ev_tick_q, en_al0_q, en_tick_q, en_al1_q;

  // Slow clock edge, gated by the clock choice
  logic src_rise, src_pulse, tick, alarm_hit;
  logic [DATA_W-1:0] cnt_q;

  rtc_src_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .src(rtc_src), .src_rise(src_rise)
  );

  assign src_pulse = src_rise & (sel_q == SEL_XTAL);

  rtc_tick_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst(rst), .restart(wr & h_div),
    .src_pulse(src_pulse), .div_val(div_q), .tick(tick)
  );

  rtc_counter #(.CNT_W(DATA_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick),
    .load(wr & h_cnt), .load_val(bus_wdata),
    .alarm_val(alarm0_q), .alarm_en(en_al0_q),
    .cnt(cnt_q), .alarm_hit(alarm_hit)
  );

  // Plain storage registers
  always_ff @(posedge clk) begin
    if (rst) begin
      alarm0_q  <= '0;
      alarm1_q  <= '0;
      scratch_q <= '0;
      div_q     <= '0;
      sel_q     <= '0;
    end else if (wr) begin
      if (h_al0) alarm0_q  <= bus_wdata;
      if (h_al1) alarm1_q  <= bus_wdata;
      if (h_scr) scratch_q <= bus_wdata;
      if (h_div) div_q     <= bus_wdata[DIV_W-1:0];
      if (h_sel) sel_q     <= bus_wdata[SEL_W-1:0];
    end
  end

  // Status: sticky events (set wins over write-1 clear) and enables
  logic st_wr;
  assign st_wr = wr & h_st;

  always_ff @(posedge clk) begin
    if (rst) begin
      ev_al0_q  <= 1'b0;
      ev_tick_q <= 1'b0;
      en_al0_q  <= 1'b0;
      en_tick_q <= 1'b0;
      en_al1_q  <= 1'b0;
    end else begin
      ev_al0_q  <= alarm_hit | (ev_al0_q  & ~(st_wr & bus_wdata[ST_AL0_EV]));
      ev_tick_q <= tick      | (ev_tick_q & ~(st_wr & bus_wdata[ST_TICK_EV]));
      if (st_wr) begin
        en_al0_q  <= bus_wdata[ST_AL0_EN];
        en_tick_q <= bus_wdata[ST_TICK_EN];
        en_al1_q  <= bus_wdata[ST_AL1_EN];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= (ev_al0_q & en_al0_q) | (ev_tick_q & en_tick_q);
  end

  // Read path, registered
  logic [DATA_W-1:0] st_word, rd_val;

  always_comb begin
    st_word             = '0;
    st_word[ST_AL0_EV]  = ev_al0_q;
    st_word[ST_TICK_EV] = ev_tick_q;
    st_word[ST_AL0_EN]  = en_al0_q;
    st_word[ST_TICK_EN] = en_tick_q;
    st_word[ST_AL1_EN]  = en_al1_q;
  end

  always_comb begin
    rd_val = '0;
    if (h_cnt) rd_val = cnt_q;
    if (h_al0) rd_val = alarm0_q;
    if (h_st)  rd_val = st_word;
    if (h_div) rd_val = DATA_W'(div_q);
    if (h_al1) rd_val = alarm1_q;
    if (h_sel) rd_val = DATA_W'(sel_q);
    if (h_scr) rd_val = scratch_q;
  end

  always_ff @(posedge clk) begin
    if (rst)     bus_rdata <= '0;
    else if (rd) bus_rdata <= rd_val;
  end
endmodule

// File: rtl/rtc_core_chk.sv
module rtc_core_chk
  import rtc_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int SEL_W  = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_en,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              irq,
  input logic [DATA_W-1:0] cnt,
  input logic              tick,
  input logic              ev_al0,
  input logic              en_al0,
  input logic              ev_tick,
  input logic              en_tick,
  input logic [SEL_W-1:0]  clk_sel
);
  logic cnt_wr, unmapped_rd, sel_off;

  assign cnt_wr      = bus_en & bus_we & (bus_addr == ADDR_W'(OFF_COUNT));
  assign unmapped_rd = bus_en & ~bus_we & ~reg_mapped(int'(bus_addr));
  assign sel_off     = (clk_sel != SEL_W'(CLK_SEL_XTAL));

  assert_unmapped_zero_R3: assert property (@(posedge clk) disable iff (rst)
    unmapped_rd |=> (bus_rdata == '0));

  assert_cnt_step_R4: assert property (@(posedge clk) disable iff (rst)
    !cnt_wr |=> (cnt == $past(cnt) || cnt == $past(cnt) + DATA_W'(1)));

  assert_gated_stable_R4: assert property (@(posedge clk) disable iff (rst)
    (sel_off && $past(sel_off) && !cnt_wr) |=> $stable(cnt));

  assert_wrap_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (!cnt_wr && cnt == '1) |=> (cnt == '1 || cnt == '0));

  assert_tick_sets_R8: assert property (@(posedge clk) disable iff (rst)
    tick |=> ev_tick);

  assert_alarm_needs_en_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(ev_al0) |-> $past(en_al0));

  assert_irq_active_R10: assert property (@(posedge clk) disable iff (rst)
    (ev_tick && en_tick) |=> irq);

  assert_irq_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    (!ev_al0 && !ev_tick) |=> !irq);
endmodule

bind rtc_core rtc_core_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .irq(irq), .cnt(cnt_q), .tick(tick),
  .ev_al0(ev_al0_q), .en_al0(en_al0_q), .ev_tick(ev_tick_q), .en_tick(en_tick_q),
  .clk_sel(sel_q)
);

// File: tb/rtc_core_bench.sv
`timescale 1ns/1ps
module rtc_core_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rtc_src = 1'b0;
  logic        bus_en = 1'b0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  always #2 clk = ~clk;            // 250 MHz
  initial forever #16 rtc_src = ~rtc_src;  // source period = 8 bus cycles

  rtc_core u_rtc_core (
    .clk(clk), .rst(rst), .rtc_src(rtc_src), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  int n_chk = 0;
  int n_fail = 0;
  int unsigned cyc = 0;
  int unsigned t0 = 0;
  int unsigned per = 32;
  bit done = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_fire = 1'b0;

  always @(posedge clk) begin
    cyc     <= cyc + 1;
    rd_fire <= bus_en & ~bus_we;
  end

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rd_fire) begin
      logic [31:0] e;
      string t;
      n_chk++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL unexpected read data actual=%h expected=none", bus_rdata);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (bus_rdata !== e) begin
          n_fail++;
          $display("FAIL %s actual=%h expected=%h", t, bus_rdata, e);
        end
      end
    end
  end

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bwr(input logic [7:0] a, input logic [31:0] d);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic brd(input logic [7:0] a, input logic [31:0] e, input string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_en = 1'b0;
  endtask

  task automatic to_cyc(input int unsigned c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic slot(input int unsigned n);
    to_cyc(t0 + n * per);
  endtask

  // Lock onto the tick grid through the first tick interrupt edge
  task automatic align(input logic [31:0] dv, input logic [31:0] x, input int unsigned p);
    logic prev;
    int k;
    per = p;
    bwr(8'h0C, dv);
    bwr(8'h08, 32'h0000_000B);
    bwr(8'h1C, 32'd3);
    prev = 1'b1;
    k = 0;
    while (!(!prev && irq) && k < 5000) begin
      prev = irq;
      @(negedge clk);
      k++;
    end
    chk({31'b0, irq}, 32'd1, "R8 tick interrupt seen during alignment");
    t0 = cyc;
    bwr(8'h00, x);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    idle(4);
    rst = 1'b0;
    idle(2);
    // R1 reset values
    brd(8'h00, 0, "R1 counter reset");
    brd(8'h04, 0, "R1 alarm0 reset");
    brd(8'h08, 0, "R1 status reset");
    brd(8'h0C, 0, "R1 divider reset");
    brd(8'h18, 0, "R1 alarm1 reset");
    brd(8'h1C, 0, "R1 clock select reset");
    brd(8'h40, 0, "R1 scratch reset");
    chk({31'b0, irq}, 0, "R1 irq reset");
    // R2 plain registers
    bwr(8'h40, 32'hA5A5_5A5A); brd(8'h40, 32'hA5A5_5A5A, "R2 scratch readback");
    bwr(8'h18, 32'h1234_5678); brd(8'h18, 32'h1234_5678, "R2 alarm1 readback");
    bwr(8'h1C, 32'hFFFF_FFFE); brd(8'h1C, 32'd2, "R2 clock select 2-bit field");
    bwr(8'h0C, 32'hFFFF_03FF); brd(8'h0C, 32'h0000_03FF, "R2 divider 16-bit field");
    // R3 unmapped offsets
    bwr(8'h10, 32'hFFFF_FFFF); brd(8'h10, 0, "R3 unmapped 0x10 reads 0");
    bwr(8'h14, 32'hFFFF_FFFF); brd(8'h14, 0, "R3 offset 0x14 reads 0");
    bwr(8'h44, 32'h0BAD_0BAD); brd(8'h40, 32'hA5A5_5A5A, "R3 unmapped write leaves scratch");
    // R7 status encoding
    bwr(8'h08, 32'hFFFF_FFFF); brd(8'h08, 32'h0000_004C, "R7 status enables only");
    idle(2);
    chk({31'b0, irq}, 0, "R10 irq low with no events");
    bwr(8'h08, 32'h0); brd(8'h08, 0, "R7 status enables cleared");
    // R5 load, R4 gating with clock select 2
    bwr(8'h00, 32'h55); brd(8'h00, 32'h55, "R5 counter load");
    idle(100);
    brd(8'h00, 32'h55, "R4 no count when select is not 3");

    // R4 rate with DIV = 3: tick every 64 bus cycles
    align(32'd3, 32'd500, 64);
    slot(0); brd(8'h00, 32'd500, "R5 load on grid");
    slot(2); brd(8'h00, 32'd502, "R4 rate with divider 3");
    bwr(8'h1C, 32'd0);

    // Main grid with DIV = 1: tick every 32 bus cycles
    align(32'd1, 32'd100, 32);
    slot(0);
    brd(8'h00, 32'd100, "R5 read after load");
    brd(8'h00, 32'd100, "R5 back-to-back read agrees");
    brd(8'h08, 32'h0A, "R8 tick event set");
    chk({31'b0, irq}, 1, "R10 irq from tick event");
    slot(1);
    brd(8'h00, 32'd101, "R4 rate with divider 1");
    bwr(8'h08, 32'h0A); idle(2);
    chk({31'b0, irq}, 0, "R10 irq drops after clear");
    brd(8'h08, 32'h08, "R7 write 1 clears tick event");
    slot(2);
    brd(8'h08, 32'h0A, "R8 tick event set again");
    chk({31'b0, irq}, 1, "R10 irq again");
    bwr(8'h08, 32'h08);
    brd(8'h08, 32'h0A, "R7 write 0 leaves event");
    bwr(8'h08, 32'h02); idle(2);
    brd(8'h08, 32'h00, "R7 clear with enable off");
    chk({31'b0, irq}, 0, "R10 irq low, enable off");
    slot(3);
    brd(8'h08, 32'h02, "R8 tick event sets with enable off");
    chk({31'b0, irq}, 0, "R10 irq gated by enable");
    brd(8'h00, 32'd103, "R4 count on grid");
    bwr(8'h04, 32'd104);
    bwr(8'h08, 32'h02);
    slot(4);
    brd(8'h08, 32'h02, "R9 no alarm event while disabled");
    chk({31'b0, irq}, 0, "R10 no irq, alarm disabled");
    bwr(8'h04, 32'd106);
    bwr(8'h08, 32'h07);
    brd(8'h04, 32'd106, "R2 alarm0 readback");
    slot(5);
    brd(8'h08, 32'h06, "R9 alarm not yet reached");
    chk({31'b0, irq}, 0, "R10 irq low before alarm");
    slot(6);
    brd(8'h08, 32'h07, "R9 alarm event on match");
    chk({31'b0, irq}, 1, "R10 irq from alarm event");
    brd(8'h00, 32'd106, "R4 counter at alarm value");
    bwr(8'h08, 32'h05); idle(2);
    chk({31'b0, irq}, 0, "R10 irq drops after alarm clear");
    brd(8'h08, 32'h06, "R7 alarm event cleared, tick event kept");
    slot(7);
    brd(8'h08, 32'h06, "R9 no re-set past the alarm value");
    bwr(8'h00, 32'hFFFF_FFFF);
    brd(8'h00, 32'hFFFF_FFFF, "R5 load all ones");
    slot(8);
    brd(8'h00, 32'h0, "R6 wrap to zero");
    to_cyc(t0 + 9 * per - 2);
    bwr(8'h00, 32'd777);
    slot(9);
    brd(8'h00, 32'd777, "R5 load wins over tick");
    bwr(8'h1C, 32'd0);
    brd(8'h1C, 32'd0, "R2 clock select cleared");
    slot(11);
    brd(8'h00, 32'd777, "R4 counter holds when deselected");
    idle(4);
    chk(exp_q.size(), 0, "R5 all reads returned");
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule